// File: doc/BRIEF.md
# Programmable Peripheral Clock Divider with Guarded Ratio Switch

This block takes the system clock and produces a slower peripheral clock. The ratio is programmable from 1 to 128. Alongside the clock it drives a one-cycle enable strobe at the divided rate, so logic that stays on the system clock can advance once per output period.

A single 32-bit control word holds an output-enable bit, a 7-bit ratio field and a read-only ready flag. A ratio change is not applied at once. It is held as pending and only loaded at the end of the output period in progress, so the output never shows a shortened pulse. While a change is pending the ready flag is low and further ratio writes are dropped.

The control word is write-protected. Two key values must arrive on a separate key port, one after the other, before a single write is taken. That write locks the word again.

Top module: `pclk_divider`

## Requirements
- R1: The ratio field value d gives an output period of d+1 system cycles: `div_stb` pulses once every d+1 cycles while enabled.
- R2: With d = 0 the output clock runs at the system clock rate, and `div_stb` is high in every cycle.
- R3: An accepted ratio write drives the ready flag (read bit 11) low on its own clock edge. The flag returns high on the edge that loads the new ratio. That edge is the end of the current output period, or the next edge when the output is disabled, so the wait is at most d_old+1 cycles.
- R4: A ratio write that arrives while the ready flag is 0 leaves the ratio field unchanged. The enable bit of the same write is still taken.
- R5: A write to the control word is ignored unless the unlock sequence came first. That sequence is key port strobes carrying `KEY_A` and then `KEY_B`, with no other key strobe between them.
- R6: One accepted write relocks the word. A key strobe that breaks the sequence restarts it, so a later `KEY_B` alone unlocks nothing.
- R7: After reset the read word is enable = 1 (bit 15), ready = 1 (bit 11) and ratio field = `RST_DIV` (bits 6:0). The default is 0.
- R8: For ratio N = d+1 ≥ 2, `div_clk` is high for the first (N+1)/2 cycles of each period and low for the rest. `div_stb` is one cycle wide, in the last cycle of the period.
- R9: With enable = 0, `div_clk` and `div_stb` stay low. After an enabling write, the first `div_stb` comes d+1 cycles after the write edge.
- R10: Read bits other than 15, 11 and 6:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_vld | input | 1 | Key port strobe |
| key_val | input | 32 | Key value presented with the strobe |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write data: bit 15 enable, bits 6:0 ratio field |
| rd_data | output | 32 | Read word: bit 15 enable, bit 11 ready, bits 6:0 ratio field |
| div_clk | output | 1 | Divided peripheral clock |
| div_stb | output | 1 | One-cycle strobe per output period |

## Verification
The assertions assume that a key strobe and a write never share a cycle. They also assume that every input changes only between clock edges, and that a write's ratio field is meant for the pending slot. The stimulus keeps to this: every key strobe and write comes from tasks that drive a single strobe for one cycle, away from the edges. Ratios come from a seeded random source limited to 0..127, and directed cases add ratio 0, a large ratio that keeps the flag low for long enough to test a refused write, and a disabled window.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int DIV_W   = 7;
  localparam int WORD_W  = 32;
  localparam int EN_BIT  = 15;
  localparam int RDY_BIT = 11;
  typedef logic [DIV_W-1:0] div_t;
  typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lock_e;
endpackage

// File: rtl/pcd_unlock.sv
module pcd_unlock
  import pcd_pkg::*;
#(
  parameter logic [WORD_W-1:0] KEY_A = 32'hC3A5_5A3C,
  parameter logic [WORD_W-1:0] KEY_B = 32'h3C5A_A5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_vld,
  input  logic [WORD_W-1:0] key_val,
  input  logic              wr_en,
  output logic              open_o
);
  lock_e st_q, st_nxt;

  always_comb begin
    st_nxt = st_q;
    if (wr_en && st_q == LK_OPEN) begin
      st_nxt = LK_IDLE;
    end else if (key_vld) begin
      if (st_q == LK_HALF && key_val == KEY_B) st_nxt = LK_OPEN;
      else if (key_val == KEY_A)               st_nxt = LK_HALF;
      else                                     st_nxt = LK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_nxt;
  end

  assign open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/pcd_regs.sv
module pcd_regs
  import pcd_pkg::*;
#(
  parameter int RST_DIV = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              swap,
  output logic              en_o,
  output logic              ready_o,
  output div_t              pend_o,
  output logic [WORD_W-1:0] rd_data
);
  logic en_q, en_nxt, busy_q, busy_nxt;
  div_t pend_q, pend_nxt;

  always_comb begin
    en_nxt   = en_q;
    busy_nxt = busy_q;
    pend_nxt = pend_q;
    if (swap) busy_nxt = 1'b0;
    if (wr_ok) begin
      en_nxt = wr_data[EN_BIT];
      if (!busy_q) begin
        pend_nxt = wr_data[DIV_W-1:0];
        busy_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      busy_q <= 1'b0;
      pend_q <= div_t'(RST_DIV);
    end else begin
      en_q   <= en_nxt;
      busy_q <= busy_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign en_o    = en_q;
  assign ready_o = !busy_q;
  assign pend_o  = pend_q;

  always_comb begin
    rd_data                = '0;
    rd_data[EN_BIT]        = en_q;
    rd_data[RDY_BIT]       = !busy_q;
    rd_data[DIV_W-1:0]     = pend_q;
  end
endmodule

// File: rtl/pcd_counter.sv
module pcd_counter
  import pcd_pkg::*;
#(
  parameter int RST_DIV = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic busy,
  input  div_t pend,
  output logic swap,
  output div_t act_o,
  output logic ph_o,
  output logic stb_o
);
  div_t cnt_q, cnt_nxt, act_q, act_nxt;
  logic run_q, ph_q, ph_nxt, stb_q, stb_nxt, at_end;
  logic [DIV_W:0] half;

  always_comb begin
    at_end  = (cnt_q == act_q);
    swap    = busy && (!run_q || at_end);
    act_nxt = swap ? pend : act_q;
    if (!run_req || !run_q || at_end) cnt_nxt = '0;
    else                              cnt_nxt = cnt_q + div_t'(1);
    half    = ({1'b0, act_nxt} + (DIV_W+1)'(2)) >> 1;
    ph_nxt  = run_req && ({1'b0, cnt_nxt} < half);
    stb_nxt = run_req && (cnt_nxt == act_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= div_t'(RST_DIV);
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      act_q <= act_nxt;
      run_q <= run_req;
      ph_q  <= ph_nxt;
      stb_q <= stb_nxt;
    end
  end

  assign act_o = act_q;
  assign ph_o  = ph_q;
  assign stb_o = stb_q;
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pcd_pkg::*;
#(
  parameter logic [31:0] KEY_A   = 32'hC3A5_5A3C,
  parameter logic [31:0] KEY_B   = 32'h3C5A_A5C3,
  parameter int          RST_DIV = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_vld,
  input  logic [31:0] key_val,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        div_clk,
  output logic        div_stb
);
  logic [1:0] rsync_q;
  logic       srst_n, unlocked, wr_ok, swap, en_q, ready, ph, gate_nq;
  div_t       pend, act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  pcd_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk(clk), .rst_n(srst_n), .key_vld(key_vld), .key_val(key_val),
    .wr_en(wr_en), .open_o(unlocked)
  );

  assign wr_ok = wr_en && unlocked;

  pcd_regs #(.RST_DIV(RST_DIV)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_ok(wr_ok), .wr_data(wr_data), .swap(swap),
    .en_o(en_q), .ready_o(ready), .pend_o(pend), .rd_data(rd_data)
  );

  pcd_counter #(.RST_DIV(RST_DIV)) u_cnt (
    .clk(clk), .rst_n(srst_n), .run_req(en_q), .busy(!ready), .pend(pend),
    .swap(swap), .act_o(act), .ph_o(ph), .stb_o(div_stb)
  );

  // Divide-by-one passes the clock through a gate updated on the low phase.
  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) gate_nq <= 1'b0;
    else         gate_nq <= en_q;
  end

  assign div_clk = (act == '0) ? (clk & gate_nq) : ph;
endmodule

// File: rtl/pcd_chk.sv
module pcd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        unlocked,
  input logic        ready,
  input logic        en,
  input logic [6:0]  act,
  input logic        ph,
  input logic        div_stb,
  input logic [31:0] rd_data
);
  // R3
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_en && unlocked));
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlocked && !ready) |=> $stable(rd_data[6:0]));
  // R5
  locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked) |=> $stable({rd_data[15], rd_data[6:0]}));
  // R6
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlocked) |=> !unlocked);
  // R8
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_stb && act != 7'd0 && ready) |=> !div_stb);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!div_stb && !ph));
  // R10
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~32'h0000_887F) == 32'h0);
endmodule

bind pclk_divider pcd_chk u_chk (
  .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .unlocked(unlocked),
  .ready(ready), .en(en_q), .act(act), .ph(ph), .div_stb(div_stb),
  .rd_data(rd_data)
);

// File: tb/sim_pclk_divider.sv
`timescale 1ns/1ps
module sim_pclk_divider;
  localparam logic [31:0] KA = 32'hC3A5_5A3C;
  localparam logic [31:0] KB = 32'h3C5A_A5C3;

  logic clk = 1'b0, rst_n = 1'b0, key_vld = 1'b0, wr_en = 1'b0;
  logic [31:0] key_val = '0, wr_data = '0, rd_data;
  logic div_clk, div_stb;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_val(key_val),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .div_clk(div_clk), .div_stb(div_stb)
  );

  function automatic logic [31:0] exp_rd(input bit en, input bit rdy, input int d);
    return {16'h0, en, 3'b0, rdy, 4'b0, 7'(d)};
  endfunction
  function automatic int exp_high(input int d);
    return (d + 2) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic key(input logic [31:0] v);
    key_vld = 1'b1; key_val = v; tick(); key_vld = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0;
  endtask

  task automatic unlock();
    key(KA); key(KB);
  endtask

  task automatic wait_ready(input int limit, input string req);
    int n = 0;
    while (!rd_data[11] && n < 400) begin tick(); n++; end
    check(n <= limit, req, n, limit);
  endtask

  task automatic measure(input int d, input string req);
    int n = 0, h = 0, w = 0;
    while (!div_stb && w < 400) begin tick(); w++; end
    do begin
      tick(); n++;
      if (div_clk) h++;
    end while (!div_stb && n < 400);
    check(n == d + 1, req, n, d + 1);
    check(h == exp_high(d), req, h, exp_high(d));
  endtask

  task automatic set_div(input int d_old, input int d);
    unlock();
    wr(32'h8000 | 32'(d));
    wait_ready(d_old + 1, "R3");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r, d, prev, n;
    bit quiet;
    r = $urandom(32'd2024);
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R7 reset word
    check(rd_data == exp_rd(1, 1, 0), "R7", rd_data, exp_rd(1, 1, 0));
    // R2 divide by one: strobe every cycle, clock high in high phase
    measure(0, "R2");
    @(negedge clk); #5;
    check(div_clk == 1'b0, "R2", div_clk, 0);
    #10;

    // R5 locked write ignored
    wr(32'h0000_0005);
    check(rd_data == exp_rd(1, 1, 0), "R5", rd_data, exp_rd(1, 1, 0));

    set_div(0, 99);
    measure(99, "R1");

    // R3 ready drops on accepted write
    unlock();
    wr(32'h8003);
    check(rd_data == exp_rd(1, 0, 3), "R3", rd_data, exp_rd(1, 0, 3));
    // R4 ratio write refused while busy
    unlock();
    wr(32'h8007);
    check(rd_data[6:0] == 7'd3, "R4", rd_data[6:0], 3);
    wait_ready(100, "R3");
    measure(3, "R8");

    // R6 relocked after one write
    wr(32'h800A);
    check(rd_data == exp_rd(1, 1, 3), "R6", rd_data, exp_rd(1, 1, 3));
    // R6 broken sequence restarts
    key(KA); key(32'h1234_5678); key(KB);
    wr(32'h800A);
    check(rd_data == exp_rd(1, 1, 3), "R6", rd_data, exp_rd(1, 1, 3));

    // R9 disable
    unlock();
    wr(32'h0003);
    check(rd_data[15] == 1'b0, "R9", rd_data[15], 0);
    tick(); tick();
    quiet = 1;
    repeat (40) begin
      tick();
      if (div_clk || div_stb) quiet = 0;
    end
    check(quiet, "R9", quiet, 1);
    // R9 clean restart: first strobe d+1 edges after the write
    unlock();
    wr(32'h8003);
    n = 0;
    while (!div_stb && n < 400) begin tick(); n++; end
    check(n == 4, "R9", n, 4);

    // R1 R8 R10 random ratios
    prev = 3;
    for (int i = 0; i < 10; i++) begin
      d = (i == 0) ? 4 : int'($urandom % 128);
      set_div(prev, d);
      measure(d, "R1");
      check(rd_data == exp_rd(1, 1, d), "R10", rd_data, exp_rd(1, 1, d));
      prev = d;
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule